// File: doc/BRIEF.md
# Parallel Disparity Cost Network

This block turns a stream of rectified image columns into matching costs for every disparity hypothesis at once. Each beat carries one column of the reference image and the column at the same horizontal position of the target image. Reference columns enter a register chain, one stage per beat. Stage `d` of the chain holds the reference column that arrived `d` beats earlier in the same line. Because a rectified pair differs only by a horizontal shift, comparing the incoming target column against every stage covers the whole search range in a single cycle. The block produces a cost column for each hypothesis in that same beat.

For each hypothesis the block also adds up the costs in the column. A winner-take-all tree then picks the smallest of these column totals. The result is one disparity estimate per accepted column, in lockstep with the input. Forming columns from line buffers, wider-window aggregation and sub-pixel refinement are handled by neighbouring blocks.

Both edges are valid/ready streams. A beat moves when valid and ready are both high. There is a single output register, so the input is ready whenever that register is empty or is being drained in the same cycle. While the output is stalled, the input is stalled too, and the delay chain does not move.

Top module: `dpn_disparity_net`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An input beat is accepted on a rising clock edge where `in_valid && in_ready`.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sol`, `out_cost`, `out_disp` and `out_min_cost` keep their values.
- R3: For a valid hypothesis `d` and row `i`, the cost is the absolute difference between target pixel `i` and row `i` of the reference column accepted `d` beats earlier in the line (d = 0 is the current beat). The result saturates at 2^COST_W-1.
- R4: A column carrying `in_sol` = 1 starts a new line. Hypothesis `d` is valid only when at least `d` columns of the current line came before the current one. Every row of an invalid hypothesis has cost 2^COST_W-1.
- R5: `out_disp` is the index `d` whose column total is smallest, where the column total is the sum over all rows of cost `d`.
- R6: When several hypotheses share the smallest total, `out_disp` is the lowest of their indices.
- R7: `out_min_cost` equals the smallest column total.
- R8: Each accepted beat produces exactly one output beat. It is visible with `out_valid` high from the edge that accepted it, in input order, and `out_sol` repeats that beat's `in_sol`.
- R9: After reset, `out_valid` is low, and the first column is treated as a line start even if `in_sol` is low.
- R10: The delay chain and the line position advance only on accepted beats. Bubbles and stalls do not change which columns are compared.
- R11: Layout: pixel `i` of a column sits at bits `[i*PIX_W +: PIX_W]`. The cost of hypothesis `d`, row `i`, sits in `out_cost[(d*COL_H+i)*COST_W +: COST_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input column pair present |
| in_ready | output | 1 | Block can accept a column pair |
| in_sol | input | 1 | Column is the first of a line |
| in_ref | input | COL_H*PIX_W | Reference image column |
| in_tgt | input | COL_H*PIX_W | Target image column |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_sol | output | 1 | Output beat belongs to a line's first column |
| out_cost | output | DISP_N*COL_H*COST_W | Cost columns, one per hypothesis |
| out_disp | output | $clog2(DISP_N) | Winning disparity |
| out_min_cost | output | COST_W+$clog2(COL_H+1) | Winning column total |

## Verification
Assertions check several properties on every cycle:
- the output is held during back-pressure;
- the winner lies inside the search range and its total is the minimum;
- no lower index shares that minimum;
- every hypothesis above zero carries the ceiling cost on a line-start beat;
- the line counter stays in range.

Other behaviour depends on history, so only the bench's reference model can show it:
- that each hypothesis compares against the right earlier column;
- that saturation is applied;
- that masking lifts one hypothesis per column after a line start;
- that stalls and bubbles leave the chain alignment intact.

The bench scenarios cover wide-range data for saturation, low-contrast data for frequent ties, flat images, short lines and heavy back-pressure.

// File: rtl/dpn_pkg.sv
package dpn_pkg;

  // Unsigned distance between two pixel values.
  function automatic int unsigned abs_gap(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/dpn_ref_chain.sv
module dpn_ref_chain #(
  parameter int DISP_N = 60,
  parameter int COL_H  = 5,
  parameter int PIX_W  = 8,
  localparam int COL_W = COL_H * PIX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    sol,
  input  logic [COL_W-1:0]        ref_col,
  output logic [DISP_N*COL_W-1:0] taps,
  output logic [DISP_N-1:0]       hyp_ok
);

  localparam int CNT_W = $clog2(DISP_N);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DISP_N - 1);

  logic [COL_W-1:0] stg [1:DISP_N-1];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] eff;

  // Columns already seen in this line, as seen by the current beat.
  assign eff = sol ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= (eff == CNT_TOP) ? eff : eff + 1'b1;
    end
  end

  for (genvar k = 0; k < DISP_N; k++) begin : g_tap
    if (k == 0) begin : g_live
      assign taps[0 +: COL_W] = ref_col;
    end else begin : g_reg
      if (k == 1) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) stg[k] <= '0;
          else if (adv) stg[k] <= ref_col;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rst_n) stg[k] <= '0;
          else if (adv) stg[k] <= stg[k-1];
        end
      end
      assign taps[k*COL_W +: COL_W] = stg[k];
    end
    assign hyp_ok[k] = (CNT_W'(k) <= eff);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_TOP) else $error("line counter out of range"); // R4

  AST_CHAIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(stg[DISP_N-1]) && $stable(cnt)) else $error("chain moved without a beat"); // R10

endmodule

// File: rtl/dpn_cost_col.sv
module dpn_cost_col import dpn_pkg::*; #(
  parameter int COL_H  = 5,
  parameter int PIX_W  = 8,
  parameter int COST_W = 8,
  parameter int SUM_W  = 11
) (
  input  logic [COL_H*PIX_W-1:0]  tgt_col,
  input  logic [COL_H*PIX_W-1:0]  ref_col,
  input  logic                    hyp_ok,
  output logic [COL_H*COST_W-1:0] cost_col,
  output logic [SUM_W-1:0]        col_sum
);

  localparam logic [COST_W-1:0] CMAX = '1;

  for (genvar r = 0; r < COL_H; r++) begin : g_row
    int unsigned gap;
    assign gap = abs_gap(32'(tgt_col[r*PIX_W +: PIX_W]), 32'(ref_col[r*PIX_W +: PIX_W]));
    assign cost_col[r*COST_W +: COST_W] =
      !hyp_ok            ? CMAX :
      (gap > 32'(CMAX))  ? CMAX : gap[COST_W-1:0];
  end

  always_comb begin
    col_sum = '0;
    for (int r = 0; r < COL_H; r++) begin
      col_sum = col_sum + SUM_W'(cost_col[r*COST_W +: COST_W]);
    end
  end

endmodule

// File: rtl/dpn_wta_tree.sv
module dpn_wta_tree #(
  parameter int DISP_N = 60,
  parameter int SUM_W  = 11,
  parameter int IDX_W  = 6
) (
  input  logic [DISP_N*SUM_W-1:0] sums,
  output logic [SUM_W-1:0]        min_sum,
  output logic [IDX_W-1:0]        min_idx
);

  localparam int LEAVES = 1 << $clog2(DISP_N);
  localparam int NODES  = 2 * LEAVES - 1;

  logic [SUM_W-1:0] val [NODES];
  logic [IDX_W-1:0] idx [NODES];

  // Heap-ordered tree: leaves left to right hold ascending indices, so
  // preferring the left child on equality keeps the lowest disparity.
  always_comb begin
    for (int l = 0; l < LEAVES; l++) begin
      val[LEAVES-1+l] = (l < DISP_N) ? sums[l*SUM_W +: SUM_W] : '1;
      idx[LEAVES-1+l] = IDX_W'(l);
    end
    for (int n = LEAVES - 2; n >= 0; n--) begin
      if (val[2*n+1] <= val[2*n+2]) begin
        val[n] = val[2*n+1];
        idx[n] = idx[2*n+1];
      end else begin
        val[n] = val[2*n+2];
        idx[n] = idx[2*n+2];
      end
    end
    min_sum = val[0];
    min_idx = idx[0];
  end

endmodule

// File: rtl/dpn_disparity_net.sv
module dpn_disparity_net #(
  parameter int DISP_N = 60,
  parameter int COL_H  = 5,
  parameter int PIX_W  = 8,
  parameter int COST_W = 8,
  localparam int COL_W = COL_H * PIX_W,
  localparam int SUM_W = COST_W + $clog2(COL_H + 1),
  localparam int IDX_W = $clog2(DISP_N)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic                           in_sol,
  input  logic [COL_W-1:0]               in_ref,
  input  logic [COL_W-1:0]               in_tgt,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic                           out_sol,
  output logic [DISP_N*COL_H*COST_W-1:0] out_cost,
  output logic [IDX_W-1:0]               out_disp,
  output logic [SUM_W-1:0]               out_min_cost
);

  localparam int CCOL_W = COL_H * COST_W;
  localparam logic [CCOL_W-1:0] CCOL_MAX = '1;

  logic                     take;
  logic [DISP_N*COL_W-1:0]  taps;
  logic [DISP_N-1:0]        hyp_ok;
  logic [DISP_N*CCOL_W-1:0] cost_d;
  logic [DISP_N*SUM_W-1:0]  sum_d;
  logic [DISP_N*SUM_W-1:0]  sum_q;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  dpn_ref_chain #(
    .DISP_N (DISP_N),
    .COL_H  (COL_H),
    .PIX_W  (PIX_W)
  ) chain_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (take),
    .sol     (in_sol),
    .ref_col (in_ref),
    .taps    (taps),
    .hyp_ok  (hyp_ok)
  );

  for (genvar d = 0; d < DISP_N; d++) begin : g_hyp
    dpn_cost_col #(
      .COL_H  (COL_H),
      .PIX_W  (PIX_W),
      .COST_W (COST_W),
      .SUM_W  (SUM_W)
    ) cost_i (
      .tgt_col  (in_tgt),
      .ref_col  (taps[d*COL_W +: COL_W]),
      .hyp_ok   (hyp_ok[d]),
      .cost_col (cost_d[d*CCOL_W +: CCOL_W]),
      .col_sum  (sum_d[d*SUM_W +: SUM_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      out_cost  <= '0;
      sum_q     <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_sol   <= in_sol;
      out_cost  <= cost_d;
      sum_q     <= sum_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  dpn_wta_tree #(
    .DISP_N (DISP_N),
    .SUM_W  (SUM_W),
    .IDX_W  (IDX_W)
  ) wta_i (
    .sums    (sum_q),
    .min_sum (out_min_cost),
    .min_idx (out_disp)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_cost) && $stable(out_sol)
      && $stable(out_disp) && $stable(out_min_cost)) else $error("output changed under stall"); // R2

  AST_BEAT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid) else $error("accepted beat lost"); // R8

  AST_DISP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_disp <= IDX_W'(DISP_N - 1)) else $error("winner out of range"); // R5

  AST_WIN_IS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> sum_q[out_disp*SUM_W +: SUM_W] == out_min_cost) else $error("winner total mismatch"); // R7

  for (genvar d = 0; d < DISP_N; d++) begin : g_chk
    AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> sum_q[d*SUM_W +: SUM_W] >= out_min_cost) else $error("total below minimum"); // R5

    AST_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (IDX_W'(d) < out_disp) |-> sum_q[d*SUM_W +: SUM_W] > out_min_cost)
      else $error("lower index ties winner"); // R6

    if (d > 0) begin : g_mask
      AST_SOL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sol |-> out_cost[d*CCOL_W +: CCOL_W] == CCOL_MAX)
        else $error("unmasked hypothesis at line start"); // R4
    end
  end

endmodule

// File: tb/dpn_disparity_net_tb_top.sv
module dpn_disparity_net_tb_top;

  localparam int D    = 8;
  localparam int H    = 4;
  localparam int P    = 8;
  localparam int C    = 6;
  localparam int SW   = C + $clog2(H + 1);
  localparam int IW   = $clog2(D);
  localparam int MAXC = (1 << C) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic              in_sol = 1'b0;
  logic [H*P-1:0]    in_ref = '0;
  logic [H*P-1:0]    in_tgt = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic              out_sol;
  logic [D*H*C-1:0]  out_cost;
  logic [IW-1:0]     out_disp;
  logic [SW-1:0]     out_min_cost;

  always #10 clk = ~clk;

  dpn_disparity_net #(.DISP_N(D), .COL_H(H), .PIX_W(P), .COST_W(C)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_sol       (in_sol),
    .in_ref       (in_ref),
    .in_tgt       (in_tgt),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_sol      (out_sol),
    .out_cost     (out_cost),
    .out_disp     (out_disp),
    .out_min_cost (out_min_cost)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference model state
  bit m_valid = 1'b0;
  bit m_sol   = 1'b0;
  int m_cost [D][H];
  int m_sum  [D];
  int m_min  = 0;
  int m_arg  = 0;
  bit m_tie  = 1'b0;
  int hist   [D][H];
  int cnt    = 0;

  // Stimulus state
  bit pend = 1'b0;
  int cur_ref [H];
  int cur_tgt [H];
  bit cur_sol = 1'b0;
  int col_pos = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_outputs();
    chk(out_valid == m_valid, "R8 R9 out_valid", int'(out_valid), int'(m_valid));
    if (m_valid) begin
      chk(out_sol == m_sol, "R8 out_sol", int'(out_sol), int'(m_sol));
      for (int d = 0; d < D; d++) begin
        for (int i = 0; i < H; i++) begin
          int a;
          a = int'(out_cost[(d*H+i)*C +: C]);
          chk(a == m_cost[d][i], "R3 R4 R10 R11 cost", a, m_cost[d][i]);
        end
      end
      chk(int'(out_min_cost) == m_min, "R7 min total", int'(out_min_cost), m_min);
      chk(int'(out_disp) == m_arg, m_tie ? "R6 tie winner" : "R5 winner",
          int'(out_disp), m_arg);
    end
  endtask

  task automatic model_step(input bit acc);
    if (acc) begin
      int eff;
      eff = cur_sol ? 0 : cnt;
      for (int k = D - 1; k > 0; k--)
        for (int i = 0; i < H; i++) hist[k][i] = hist[k-1][i];
      for (int i = 0; i < H; i++) hist[0][i] = cur_ref[i];
      m_min = -1;
      m_tie = 1'b0;
      for (int d = 0; d < D; d++) begin
        m_sum[d] = 0;
        for (int i = 0; i < H; i++) begin
          int g;
          g = cur_tgt[i] - hist[d][i];
          if (g < 0) g = -g;
          if (g > MAXC) g = MAXC;
          m_cost[d][i] = (d <= eff) ? g : MAXC;
          m_sum[d] += m_cost[d][i];
        end
        if (m_min < 0 || m_sum[d] < m_min) begin
          m_min = m_sum[d];
          m_arg = d;
          m_tie = 1'b0;
        end else if (m_sum[d] == m_min) begin
          m_tie = 1'b1;
        end
      end
      m_valid = 1'b1;
      m_sol   = cur_sol;
      cnt     = (eff + 1 > D - 1) ? D - 1 : eff + 1;
    end else if (out_ready) begin
      m_valid = 1'b0;
    end
  endtask

  task automatic run_phase(input int cycles, input int pv, input int pr,
                           input int base, input int span, input int line_w);
    for (int c = 0; c < cycles; c++) begin
      bit exp_ready;
      bit acc;
      compare_outputs();
      if (!pend && $urandom_range(99) < pv) begin
        pend    = 1'b1;
        cur_sol = (col_pos == 0);
        for (int i = 0; i < H; i++) begin
          cur_ref[i] = base + $urandom_range(span - 1);
          cur_tgt[i] = base + $urandom_range(span - 1);
        end
      end
      in_valid = pend;
      in_sol   = pend ? cur_sol : 1'b0;
      for (int i = 0; i < H; i++) begin
        in_ref[i*P +: P] = P'(cur_ref[i]);
        in_tgt[i*P +: P] = P'(cur_tgt[i]);
      end
      out_ready = ($urandom_range(99) < pr);
      #1;
      exp_ready = !m_valid || out_ready;
      chk(in_ready == exp_ready, "R1 in_ready", int'(in_ready), int'(exp_ready));
      acc = pend && exp_ready;
      model_step(acc);
      if (acc) begin
        pend    = 1'b0;
        col_pos = (col_pos + 1) % line_w;
      end
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    for (int k = 0; k < D; k++)
      for (int i = 0; i < H; i++) hist[k][i] = 0;
    for (int i = 0; i < H; i++) begin
      cur_ref[i] = 0;
      cur_tgt[i] = 0;
    end
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 R9 reset in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    run_phase(700, 80, 80, 0, 256, 12);  // wide range, saturation
    run_phase(700, 100, 100, 0, 4, 5);   // low contrast, ties, short lines
    run_phase(500, 60, 90, 77, 1, 11);   // flat image
    run_phase(700, 90, 30, 0, 64, 13);   // heavy back-pressure
    run_phase(400, 40, 100, 100, 40, 9); // bubbles
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule